// File: doc/BRIEF.md
# H-Bridge Decay Sequencer with Stall Detection

This block sequences one H-bridge through each current-regulation PWM period. A period opens with an energising phase. That phase closes once the coil-current comparator reports that the target has been reached, after a minimum blanking interval. A cross-conduction guard interval always follows. The bridge then enters the decay behaviour that has been selected:
- Slow decay, which recirculates the current.
- Fast decay, which returns energy to the supply.
- Mixed decay, which starts fast and falls back to slow, either when the current undershoots the target or when a selectable timer runs out.
- Automatic decay, which picks slow decay while the current profile climbs, and fast or mixed decay while it descends.

The block also counts the length of each energising phase. A stalled rotor produces no back-EMF, so the coil reaches its target early and the phase becomes short. When a finished phase is shorter than a programmable threshold, a sticky stall flag is raised. Control software clears this flag when it reads it. All timing is expressed in clock cycles, through parameters.

Top module: `decay_seq`

## Requirements
- R1: After reset, `bridge_state` is SLOW, `on_count` is 0 and `stall` is 0. The bridge state encoding is SLOW=0, ON=1, DEAD=2, FAST=3.
- R2: A `period_start` pulse while the bridge is SLOW makes the state ON on the next cycle. Without a pulse, SLOW persists.
- R3: ON ends once `cur_above` is seen high, but never before BLANK cycles of ON. The ON length in cycles is max(cycles until the flag is seen, BLANK).
- R4: Every exit from ON is followed by exactly DEAD_CYC cycles of DEAD. No transition goes from ON to FAST or from FAST to ON directly.
- R5: After DEAD, `decay_mode`=0 gives SLOW and `decay_mode`=1 gives FAST. Either state is held until the next `period_start`.
- R6: With `decay_mode`=2 and `mix_by_timer`=0, the bridge stays FAST until `cur_above` is seen low, then goes SLOW.
- R7: With `decay_mode`=2 and `mix_by_timer`=1, the bridge stays FAST for TMD_SHORT cycles (`tmd_long`=0) or TMD_LONG cycles (`tmd_long`=1), then goes SLOW. In this variant `cur_above` has no effect.
- R8: With `decay_mode`=3, the bridge behaves as follows:
  - If `profile_falling`=0, it behaves as slow decay.
  - If `profile_falling`=1 and `auto_pure_fast`=1, it behaves as pure fast decay.
  - If `profile_falling`=1 and `auto_pure_fast`=0, it behaves as mixed decay with the variant chosen by `mix_by_timer`.
- R9: On each exit from ON, `on_count` takes the number of ON cycles, saturated at 2^CNT_W-1. It is visible from the first DEAD cycle.
- R10: On each exit from ON, `stall` is set if the new count is below `stall_thr`. `stall_ack` clears it. When both happen in the same cycle, setting wins. Otherwise `stall` keeps its value.
- R11: A `period_start` during ON ends ON, and the count is recorded. A `period_start` during FAST or DEAD forces the path through DEAD. In every case, after DEAD the bridge returns to ON instead of decaying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_start | input | 1 | Pulse that opens a new PWM period |
| cur_above | input | 1 | Coil current at or above target |
| decay_mode | input | 2 | 0 slow, 1 fast, 2 mixed, 3 automatic |
| profile_falling | input | 1 | Current profile is descending |
| auto_pure_fast | input | 1 | Automatic mode uses pure fast decay when descending |
| mix_by_timer | input | 1 | Mixed decay ends on timer (1) or undershoot (0) |
| tmd_long | input | 1 | Selects the long mixed-decay timer |
| stall_thr | input | CNT_W | Stall threshold for the ON count |
| stall_ack | input | 1 | Read strobe that clears the stall flag |
| bridge_state | output | 2 | Current bridge state |
| on_count | output | CNT_W | Length of the last ON phase |
| stall | output | 1 | Sticky stall flag |

## Verification
The bench builds the block with a three-cycle guard interval, a blanking time of three cycles, and mixed-decay timers of four and seven cycles. With these small values, every combination of the decay controls (all 64 of them) can be run through a full period, with the state checked on every cycle. Because the mixed timers are longer than the three-cycle undershoot delay, the bench can tell the two mixed variants apart. The six-bit counter reaches saturation within a sweep of ON lengths up to seventy cycles. The bench also covers the sticky stall flag, including a clear strobe that arrives in the same cycle as a set, and a restart of the period during ON and during FAST.

// File: rtl/decay_pkg.sv
package decay_pkg;

  typedef enum logic [1:0] {
    BR_SLOW = 2'd0,
    BR_ON   = 2'd1,
    BR_DEAD = 2'd2,
    BR_FAST = 2'd3
  } bridge_e;

  typedef enum logic [1:0] {
    DM_SLOW  = 2'd0,
    DM_FAST  = 2'd1,
    DM_MIXED = 2'd2,
    DM_AUTO  = 2'd3
  } decay_mode_e;

  typedef struct packed {
    logic fast;   // enter FAST after the guard interval
    logic mixed;  // FAST may hand over to SLOW
  } decay_pick_t;

  // Decay choice for the interval after the guard time.
  function automatic decay_pick_t pick_decay(input logic [1:0] mode,
                                             input logic falling,
                                             input logic auto_pure);
    decay_pick_t p;
    p = '0;
    unique case (decay_mode_e'(mode))
      DM_SLOW:  p = '0;
      DM_FAST:  p.fast = 1'b1;
      DM_MIXED: begin p.fast = 1'b1; p.mixed = 1'b1; end
      DM_AUTO:  begin p.fast = falling; p.mixed = falling & ~auto_pure; end
      default:  p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/decay_span_timer.sv
module decay_span_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  // done in the cycle that completes 'limit' cycles since restart
  assign done = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/decay_on_meter.sv
module decay_on_meter #(
  parameter int CNT_W = 6,
  parameter int BLANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_on,
  input  logic             on_exit,
  input  logic [CNT_W-1:0] thr,
  input  logic             ack,
  output logic             blank_done,
  output logic [CNT_W-1:0] on_count,
  output logic             stall
);
  localparam logic [CNT_W-1:0] BLANK_M1 = CNT_W'(BLANK - 1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_len;
  logic             below_thr;

  assign run_len    = sat_inc(run_q);
  assign below_thr  = run_len < thr;
  assign blank_done = run_q >= BLANK_M1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (in_on && !on_exit) run_q <= run_len;
    else                        run_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_count <= '0;
      stall    <= 1'b0;
    end else begin
      if (on_exit) on_count <= run_len;
      if (on_exit && below_thr) stall <= 1'b1;
      else if (ack)             stall <= 1'b0;
    end
  end

  // R10: flag holds while no read strobe comes
  a_r10_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !ack) |=> stall);
  // R10: a newly raised flag always goes with a count below threshold
  a_r10_rise_below_thr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> (on_count < $past(thr)));
  // R9: the published count only changes on an ON exit
  a_r9_count_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !on_exit |=> $stable(on_count));
endmodule

// File: rtl/decay_seq.sv
module decay_seq
  import decay_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int BLANK     = 4,
  parameter int DEAD_CYC  = 8,
  parameter int TMD_SHORT = 16,
  parameter int TMD_LONG  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start,
  input  logic             cur_above,
  input  logic [1:0]       decay_mode,
  input  logic             profile_falling,
  input  logic             auto_pure_fast,
  input  logic             mix_by_timer,
  input  logic             tmd_long,
  input  logic [CNT_W-1:0] stall_thr,
  input  logic             stall_ack,
  output logic [1:0]       bridge_state,
  output logic [CNT_W-1:0] on_count,
  output logic             stall
);
  localparam int SPAN_MAX = (DEAD_CYC > TMD_LONG) ?
                            ((DEAD_CYC > TMD_SHORT) ? DEAD_CYC : TMD_SHORT) :
                            ((TMD_LONG > TMD_SHORT) ? TMD_LONG : TMD_SHORT);
  localparam int TW = $clog2(SPAN_MAX + 1) + 1;

  bridge_e     state_q, state_n;
  logic        pend_q, pend_n;
  logic        mix_q, mix_n;
  logic        mtim_q, mtim_n;
  decay_pick_t pick;

  // named internal events
  logic dead_done, mix_done, blank_done;
  logic on_exit, dead_enter, fast_enter, undershoot;
  logic [TW-1:0] mix_limit;

  assign pick       = pick_decay(decay_mode, profile_falling, auto_pure_fast);
  assign undershoot = !cur_above;
  assign mix_limit  = tmd_long ? TW'(TMD_LONG) : TW'(TMD_SHORT);

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    mix_n   = mix_q;
    mtim_n  = mtim_q;
    unique case (state_q)
      BR_SLOW: if (period_start) state_n = BR_ON;
      BR_ON: begin
        if (period_start) begin
          state_n = BR_DEAD; pend_n = 1'b1;
        end else if (cur_above && blank_done) begin
          state_n = BR_DEAD; pend_n = 1'b0;
        end
      end
      BR_DEAD: begin
        if (period_start) pend_n = 1'b1;
        if (dead_done) begin
          if (pend_n) begin
            state_n = BR_ON; pend_n = 1'b0;
          end else if (pick.fast) begin
            state_n = BR_FAST; mix_n = pick.mixed; mtim_n = mix_by_timer;
          end else begin
            state_n = BR_SLOW;
          end
        end
      end
      BR_FAST: begin
        if (period_start) begin
          state_n = BR_DEAD; pend_n = 1'b1;
        end else if (mix_q && (mtim_q ? mix_done : undershoot)) begin
          state_n = BR_SLOW;
        end
      end
      default: state_n = BR_SLOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BR_SLOW;
      pend_q  <= 1'b0;
      mix_q   <= 1'b0;
      mtim_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      mix_q   <= mix_n;
      mtim_q  <= mtim_n;
    end
  end

  assign on_exit    = (state_q == BR_ON)   && (state_n != BR_ON);
  assign dead_enter = (state_q != BR_DEAD) && (state_n == BR_DEAD);
  assign fast_enter = (state_q != BR_FAST) && (state_n == BR_FAST);
  assign bridge_state = state_q;

  decay_span_timer #(.TW(TW)) u_dead_tmr (
    .clk(clk), .rst_n(rst_n), .restart(dead_enter),
    .limit(TW'(DEAD_CYC)), .done(dead_done));

  decay_span_timer #(.TW(TW)) u_mix_tmr (
    .clk(clk), .rst_n(rst_n), .restart(fast_enter),
    .limit(mix_limit), .done(mix_done));

  decay_on_meter #(.CNT_W(CNT_W), .BLANK(BLANK)) u_meter (
    .clk(clk), .rst_n(rst_n), .in_on(state_q == BR_ON), .on_exit(on_exit),
    .thr(stall_thr), .ack(stall_ack), .blank_done(blank_done),
    .on_count(on_count), .stall(stall));

  // R4: ON and FAST never follow each other directly
  a_r4_on_not_to_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BR_ON) |=> (state_q != BR_FAST));
  a_r4_fast_not_to_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BR_FAST) |=> (state_q != BR_ON));
  // R4: the guard interval is held until its timer completes
  a_r4_dead_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BR_DEAD && !dead_done) |=> (state_q == BR_DEAD));
  // R3: a comparator-ended ON phase is at least BLANK cycles long
  a_r3_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == BR_ON && state_q == BR_DEAD && !$past(period_start))
      |-> (on_count >= CNT_W'(BLANK)));
  // R7: timed mixed decay stays fast until the timer completes
  a_r7_mix_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BR_FAST && mix_q && mtim_q && !mix_done && !period_start)
      |=> (state_q == BR_FAST));
  // R2: SLOW persists without a period start
  a_r2_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BR_SLOW && !period_start) |=> (state_q == BR_SLOW));
endmodule

// File: tb/decay_seq_test.sv
module decay_seq_test;
  localparam int CW = 6, BL = 3, DC = 3, TS = 4, TL = 7;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_start = 1'b0, cur_above = 1'b0;
  logic [1:0] decay_mode = 2'd0;
  logic profile_falling = 1'b0, auto_pure_fast = 1'b0;
  logic mix_by_timer = 1'b0, tmd_long = 1'b0;
  logic [CW-1:0] stall_thr = '0;
  logic stall_ack = 1'b0;
  logic [1:0] bridge_state;
  logic [CW-1:0] on_count;
  logic stall;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit stall_m = 1'b0;

  always #5 clk = ~clk;

  decay_seq #(.CNT_W(CW), .BLANK(BL), .DEAD_CYC(DC), .TMD_SHORT(TS),
              .TMD_LONG(TL)) uut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start),
    .cur_above(cur_above), .decay_mode(decay_mode),
    .profile_falling(profile_falling), .auto_pure_fast(auto_pure_fast),
    .mix_by_timer(mix_by_timer), .tmd_long(tmd_long), .stall_thr(stall_thr),
    .stall_ack(stall_ack), .bridge_state(bridge_state), .on_count(on_count),
    .stall(stall));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; period_start = 1'b0; cur_above = 1'b0; stall_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    stall_m = 1'b0;
  endtask

  // decay kind from R5..R8: 0 slow, 1 pure fast, 2 mixed undershoot, 3 mixed timer
  function automatic int kind_of();
    int mixk;
    mixk = mix_by_timer ? 3 : 2;
    case (decay_mode)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return mixk;
      default: return profile_falling ? (auto_pure_fast ? 1 : mixk) : 0;
    endcase
  endfunction

  // One period from SLOW; cur_above seen from cycle h+1, dropped at E+2.
  task automatic do_period(input int h, input int thr, input int ack_at);
    int l, e, k, t, cnt, st;
    bit sexp;
    l = (h + 1 > BL) ? h + 1 : BL;
    e = l + DC + 1;
    k = kind_of();
    t = tmd_long ? TL : TS;
    cnt = (l > CMAX) ? CMAX : l;
    stall_thr = CW'(thr);
    @(negedge clk);
    period_start = 1'b1; cur_above = 1'b0;
    for (int c = 1; c <= e + 10; c++) begin
      @(negedge clk);
      period_start = 1'b0;
      stall_ack = (c == ack_at);
      cur_above = (c >= h + 1) && (c < e + 2);
      if (c <= l) chk("R3 on phase", bridge_state, 1);
      else if (c < e) chk("R4 guard interval", bridge_state, 2);
      else begin
        case (k)
          0: st = 0;
          1: st = 3;
          2: st = (c <= e + 2) ? 3 : 0;
          default: st = (c <= e + t - 1) ? 3 : 0;
        endcase
        case (k)
          0: chk("R5/R8 slow decay", bridge_state, st);
          1: chk("R5/R8 fast decay", bridge_state, st);
          2: chk("R6 mixed undershoot", bridge_state, st);
          default: chk("R7 mixed timer", bridge_state, st);
        endcase
      end
      if (c == l + 1) begin
        chk("R9 on count", on_count, cnt);
        sexp = (cnt < thr) || (stall_m && !(ack_at >= 1 && ack_at <= l));
        chk("R10 stall flag", stall, sexp);
        stall_m = sexp;
      end
    end
    stall_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    do_reset();
    chk("R1 reset state", bridge_state, 0);
    chk("R1 reset count", on_count, 0);
    chk("R1 reset stall", stall, 0);
    // R2 idle SLOW holds
    repeat (3) @(negedge clk);
    chk("R2 idle slow", bridge_state, 0);

    // R5..R8 every decay configuration
    for (int cfg = 0; cfg < 64; cfg++) begin
      do_reset();
      decay_mode      = cfg[1:0];
      profile_falling = cfg[2];
      auto_pure_fast  = cfg[3];
      mix_by_timer    = cfg[4];
      tmd_long        = cfg[5];
      do_period(cfg % 5, (cfg % 6) + 1, 0);
    end

    // R3/R9 ON length sweep including saturation
    decay_mode = 2'd0;
    for (int h = 0; h < 70; h++) begin
      do_reset();
      do_period(h, 40, 0);
    end

    // R10 sticky flag and clear
    do_reset();
    do_period(0, 10, 0);          // L=3 < 10: set
    do_period(20, 10, 0);         // L=21: stays set
    chk("R10 sticky", stall, 1);
    @(negedge clk); stall_ack = 1'b1;
    @(negedge clk); stall_ack = 1'b0;
    chk("R10 cleared by ack", stall, 0);
    stall_m = 1'b0;
    do_period(0, 10, 3);          // ack together with set: set wins
    chk("R10 set beats ack", stall, 1);
    do_period(6, 5, 2);           // ack earlier, L=7 >= 5: cleared
    chk("R10 ack before exit", stall, 0);

    // R11 restart during ON
    do_reset();
    decay_mode = 2'd0;
    stall_thr = 6'd2;
    @(negedge clk); period_start = 1'b1; cur_above = 1'b0;
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      period_start = (c == 5);
      if (c <= 5) chk("R11 on before restart", bridge_state, 1);
      else if (c <= 8) chk("R11 guard after restart", bridge_state, 2);
      else chk("R11 back to on", bridge_state, 1);
      if (c == 6) chk("R11 count of cut phase", on_count, 5);
    end

    // R11 restart during FAST
    do_reset();
    decay_mode = 2'd1;
    do_period(0, 1, 0);
    chk("R5 fast still held", bridge_state, 3);
    @(negedge clk); period_start = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      period_start = 1'b0;
      if (c <= 3) chk("R11 fast to guard", bridge_state, 2);
      else chk("R11 guard to on", bridge_state, 1);
    end

    // R2 start from SLOW goes ON in one cycle
    do_reset();
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    chk("R2 slow to on", bridge_state, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule